// File: doc/BRIEF.md
# Windowed Stack Pointer Unit

This block holds a processor's stack pointer. It presents the pointer as a 16-bit address but stores only its low 10 bits. Every value it shows is placed inside a 1 KiB high-speed RAM window that runs from 0xFB00 to 0xFEFF. A written value, or a value produced by stepping the pointer, can land outside that window. In that case the stored low bits select the in-window alias, so the pointer never wraps across the full 16-bit address space.

Each cycle the core may request one of three operations. A load sets the pointer to a 16-bit value. A push first moves the pointer down by one and then uses the new value as the memory address. A pop uses the current value as the memory address and then moves the pointer up by one. The block gives the stack memory address for the current cycle combinationally, together with a valid strobe. The pointer's canonical 16-bit form can always be read. After reset the pointer contents are undefined, so software loads it before it uses the stack.

Top module: `sp_window_unit`

## Requirements
- R1: A load stores bits [9:0] of `sp_wr_data` and drops bits [15:10]. From the next cycle, `sp_rd_data` reads as 0xF800|v when the stored 10-bit value v is 0x300 or above, and as 0xFC00|v when it is below 0x300. For example, loading 0xFF00 reads back as 0xFB00.
- R2: `sp_rd_data` always lies in the range 0xFB00 to 0xFEFF.
- R3: During a push cycle, `stk_addr_vld` is 1 and `stk_addr` equals the canonical form of (stored value − 1) mod 1024.
- R4: After a push, `sp_rd_data` equals the `stk_addr` that the push gave.
- R5: During a pop cycle, `stk_addr_vld` is 1 and `stk_addr` equals the current `sp_rd_data`. After the pop, the stored value has grown by 1 mod 1024.
- R6: The pointer wraps inside the window. A push with `sp_rd_data` at 0xFB00 gives address 0xFEFF. A pop at 0xFEFF leaves the pointer at 0xFB00.
- R7: A load takes priority over push and pop in the same cycle. The loaded value is stored and `stk_addr_vld` stays 0.
- R8: When push and pop are requested together with no load, the push is carried out and the pop is ignored.
- R9: In a cycle with no request, `stk_addr_vld` is 0 and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; pointer becomes undefined |
| sp_wr_en | input | 1 | Load the pointer |
| sp_wr_data | input | 16 | Value to load; only bits [9:0] are kept |
| push_req | input | 1 | Pre-decrement and give the address |
| pop_req | input | 1 | Give the address and then post-increment |
| sp_rd_data | output | 16 | Canonical in-window pointer value |
| stk_addr | output | 16 | Stack memory address for this cycle |
| stk_addr_vld | output | 1 | `stk_addr` is valid (a push or a pop is carried out) |

## Verification
The embedded assertions check several properties on every cycle. They check that the readback and any valid address stay inside the window, and that a load wins over the other requests. They check that the stored field steps by exactly −1, +1 or 0 after a push, a pop or an idle cycle, and that pushing from the bottom of the window gives its top. The bench's sweep is the only thing that shows the exact mapping from every one of the 1024 stored values to its 16-bit address. Only the bench's scenarios show that a pushed address becomes the next readback, and that a pop at 0xFEFF returns to 0xFB00.

// File: rtl/sp_win_pkg.sv
package sp_win_pkg;
  localparam int SP_W     = 16;
  localparam int KEEP_W   = 10;
  localparam logic [SP_W-1:0] WIN_BASE = 16'hFB00;
  localparam logic [SP_W-1:0] WIN_TOP  = WIN_BASE + SP_W'((1 << KEEP_W) - 1);

  typedef logic [KEEP_W-1:0] keep_t;
  typedef logic [SP_W-1:0]   addr_t;

  typedef enum logic [1:0] {OP_IDLE, OP_LOAD, OP_PUSH, OP_POP} sp_op_e;

  // keep only the settable low bits
  function automatic keep_t fold(addr_t a);
    return a[KEEP_W-1:0];
  endfunction

  // offset from window base, then add base
  function automatic addr_t canon(keep_t k);
    keep_t off;
    off = k - WIN_BASE[KEEP_W-1:0];
    return WIN_BASE + addr_t'(off);
  endfunction

  function automatic keep_t step_dn(keep_t k);
    return k - keep_t'(1);
  endfunction

  function automatic keep_t step_up(keep_t k);
    return k + keep_t'(1);
  endfunction
endpackage

// File: rtl/sp_op_arb.sv
module sp_op_arb
  import sp_win_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  logic   push,
  input  logic   pop,
  output sp_op_e op
);
  always_comb begin
    if (wr_en)     op = OP_LOAD;
    else if (push) op = OP_PUSH;
    else if (pop)  op = OP_POP;
    else           op = OP_IDLE;
  end

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> op == OP_LOAD);
  // R8
  push_over_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && push && pop) |-> op == OP_PUSH);
endmodule

// File: rtl/sp_store.sv
module sp_store
  import sp_win_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sp_op_e op,
  input  addr_t  wr_val,
  output keep_t  q
);
  keep_t nxt;

  always_comb begin
    case (op)
      OP_LOAD: nxt = fold(wr_val);
      OP_PUSH: nxt = step_dn(q);
      OP_POP:  nxt = step_up(q);
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 'x;
    else        q <= nxt;
  end

  // R1
  load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> q == $past(wr_val[KEEP_W-1:0]));
  // R4
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_PUSH |=> q == keep_t'($past(q) - keep_t'(1)));
  // R5
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_POP |=> q == keep_t'($past(q) + keep_t'(1)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_IDLE |=> $stable(q));
endmodule

// File: rtl/sp_addr_map.sv
module sp_addr_map
  import sp_win_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sp_op_e op,
  input  keep_t  q,
  output addr_t  rd_val,
  output addr_t  mem_addr,
  output logic   mem_vld
);
  wire addr_t push_addr = canon(step_dn(q));
  wire addr_t pop_addr  = canon(q);
  wire        is_push   = (op == OP_PUSH);
  wire        is_pop    = (op == OP_POP);

  assign rd_val   = canon(q);
  assign mem_vld  = is_push | is_pop;
  assign mem_addr = is_push ? push_addr : pop_addr;

  // R2
  rd_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op != OP_LOAD |-> (rd_val >= WIN_BASE && rd_val <= WIN_TOP));
  // R3
  addr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld |-> (mem_addr >= WIN_BASE && mem_addr <= WIN_TOP));
  // R5
  pop_addr_is_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pop |-> mem_addr == rd_val);
  // R6
  push_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_push && rd_val == WIN_BASE) |-> mem_addr == WIN_TOP);
  // R7
  load_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |-> !mem_vld);
endmodule

// File: rtl/sp_window_unit.sv
module sp_window_unit
  import sp_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sp_wr_en,
  input  logic [15:0] sp_wr_data,
  input  logic        push_req,
  input  logic        pop_req,
  output logic [15:0] sp_rd_data,
  output logic [15:0] stk_addr,
  output logic        stk_addr_vld
);
  sp_op_e op_w;
  keep_t  q_w;

  sp_op_arb u_arb (
    .clk(clk), .rst_n(rst_n), .wr_en(sp_wr_en), .push(push_req),
    .pop(pop_req), .op(op_w)
  );

  sp_store u_store (
    .clk(clk), .rst_n(rst_n), .op(op_w), .wr_val(sp_wr_data), .q(q_w)
  );

  sp_addr_map u_map (
    .clk(clk), .rst_n(rst_n), .op(op_w), .q(q_w),
    .rd_val(sp_rd_data), .mem_addr(stk_addr), .mem_vld(stk_addr_vld)
  );
endmodule

// File: tb/sim_sp_window_unit.sv
module sim_sp_window_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sp_wr_en = 0;
  logic [15:0] sp_wr_data = 0;
  logic        push_req = 0;
  logic        pop_req = 0;
  logic [15:0] sp_rd_data, stk_addr;
  logic        stk_addr_vld;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sp_window_unit u0 (.*);

  // bench's own form of the window mapping
  function automatic logic [15:0] model(int v);
    int k = v & 1023;
    return (k >= 'h300) ? (16'hF800 | 16'(k)) : (16'hFC00 | 16'(k));
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after negedge, sample before posedge, then cross the edge
  task automatic cyc(bit w, logic [15:0] d, bit pu, bit po);
    @(negedge clk);
    sp_wr_en = w; sp_wr_data = d; push_req = pu; pop_req = po;
    #2;
  endtask

  task automatic idle_wait();
    @(negedge clk);
    sp_wr_en = 0; push_req = 0; pop_req = 0;
    #2;
  endtask

  initial begin
    #100000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle_wait();
    chk("R9 reset vld", {15'b0, stk_addr_vld}, 16'h0);

    // R1 example and R6 wrap cases
    cyc(1, 16'hFF00, 0, 0);
    idle_wait();
    chk("R1 FF00 read", sp_rd_data, 16'hFB00);
    cyc(0, 0, 1, 0);
    chk("R6 push wrap addr", stk_addr, 16'hFEFF);
    idle_wait();
    chk("R4 push wrap read", sp_rd_data, 16'hFEFF);
    cyc(0, 0, 0, 1);
    chk("R5 pop addr", stk_addr, 16'hFEFF);
    idle_wait();
    chk("R6 pop wrap read", sp_rd_data, 16'hFB00);

    // sweep every stored value, with the upper bits varied
    for (int v = 0; v < 1024; v++) begin
      logic [15:0] wd;
      wd = {6'(v * 37 + 5), 10'(v)};
      cyc(1, wd, 0, 0);
      chk("R7 load vld", {15'b0, stk_addr_vld}, 16'h0);
      idle_wait();
      chk("R1 read", sp_rd_data, model(v));
      chk("R9 idle vld", {15'b0, stk_addr_vld}, 16'h0);
      if (sp_rd_data < 16'hFB00 || sp_rd_data > 16'hFEFF)
        chk("R2 window", sp_rd_data, model(v));
      cyc(0, 0, 1, 0);
      chk("R3 push addr", stk_addr, model(v - 1));
      chk("R3 push vld", {15'b0, stk_addr_vld}, 16'h1);
      idle_wait();
      chk("R4 read after push", sp_rd_data, model(v - 1));
      cyc(0, 0, 0, 1);
      chk("R5 pop addr", stk_addr, model(v - 1));
      idle_wait();
      chk("R5 read after pop", sp_rd_data, model(v));
    end

    // R7: load with push and pop
    cyc(1, 16'h0123, 1, 1);
    chk("R7 vld low", {15'b0, stk_addr_vld}, 16'h0);
    idle_wait();
    chk("R7 loaded", sp_rd_data, model('h123));
    // R8: push and pop together
    cyc(0, 0, 1, 1);
    chk("R8 push addr", stk_addr, model('h122));
    idle_wait();
    chk("R8 read", sp_rd_data, model('h122));
    // R9: several idle cycles hold the value
    repeat (4) idle_wait();
    chk("R9 hold", sp_rd_data, model('h122));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule